// File: doc/BRIEF.md
# SPI Master Shift Engine

This engine runs one block transfer on an SPI bus as the serial core of a memory-mapped SPI controller. When `go` arrives it pulls words from a transmit FIFO port and shifts them out on MOSI, most significant bit first. At the same time it samples MISO and pushes each completed received word to a receive FIFO port. It keeps doing this until the programmed number of words is done. The word length, the clock polarity and phase, and the chip-select behaviour come from static configuration inputs. These inputs must stay stable while `busy` is high.

SCLK runs at a quarter of the core clock: each half-period lasts two core cycles. Chip select can be timed by the engine or left to software. When the engine times it, there is a programmable setup delay before the first word and a programmable hold delay after the last word. Between words, chip select is either kept active or released for one SCLK period. The engine walks a state machine with these states:

- `ST_IDLE`: waiting for `go`.
- `ST_SETUP`: chip select is active, waiting out the setup delay.
- `ST_LOAD`: fetching the next transmit word. It stalls here while the transmit FIFO is empty.
- `ST_SHIFT`: clocking one word.
- `ST_HOLD`: chip select is still active, waiting out the hold delay.
- `ST_GAP`: chip select is released between words.

The transitions are:

- IDLE to SETUP on `go` in timed mode, or IDLE to LOAD on `go` in software mode.
- SETUP to LOAD when the setup delay expires.
- LOAD to SHIFT when a word is available, or at once if transmit is disabled.
- SHIFT back to LOAD when the word ends and more words follow, provided chip select is kept or under software control.
- SHIFT to HOLD when the word ends in timed mode, after the last word or when chip select is not kept.
- SHIFT to IDLE after the last word in software mode.
- HOLD to IDLE after the last word, or HOLD to GAP when more words follow.
- GAP to SETUP after one SCLK period.

Top module: `spi_shift_engine`

## Requirements
- R1: A word has `cfg_bit_len`+1 bits (1 to 32). The low bits of the transmit word are sent MSB first, and transmit bits above the word length are never sent.
- R2: SCLK rests at `cfg_cpol` whenever the engine is not busy. Within a word, successive SCLK edges are 2 core cycles apart, so one SCLK period is 4 core cycles.
- R3: MISO is sampled on the leading edge when `cfg_cpha`=0 and on the trailing edge when `cfg_cpha`=1. `rx_data` carries the received bits, first bit in the MSB of the word, with zeros above the word length, in the cycle in which `rx_push` is 1.
- R4: `cfg_cs_sel` picks one line of `cs`. Line i is active high when `cfg_cs_pol[i]`=1 and active low otherwise. Every line that is not selected stays at its inactive level.
- R5: With `cfg_cs_sw`=1, the selected line is driven to the raw level of `cfg_cs_val` at all times, including while idle and during a block.
- R6: With timed chip select and a transmit word waiting, the first SCLK edge in mode `cfg_cpha`=1 comes (`cfg_cs_setup`+1)*4+1 core cycles after chip select goes active.
- R7: With timed chip select in mode `cfg_cpha`=0, chip select goes inactive (`cfg_cs_hold`+1)*4 core cycles after the final SCLK edge of the block.
- R8: With timed chip select and `cfg_cs_keep`=1, chip select stays active across all words of a block. With `cfg_cs_keep`=0, chip select is released for 4 core cycles between words, after a hold delay and before a fresh setup delay.
- R9: With `cfg_tx_en`=0, no word is popped, MOSI stays 0 and SCLK still runs. With `cfg_rx_en`=0, no word is pushed, and the transmit side is unaffected.
- R10: A block moves `cfg_blk_words`+1 words. `busy` is 1 from the edge that takes `go` until the block ends, and a `go` that arrives while busy has no effect.
- R11: `ready` becomes 1 on the edge where the block ends and clears on the edge after `ready_clr`=1. When both happen in the same cycle, the set wins.
- R12: If the transmit FIFO is empty when a word is due, SCLK holds its idle level and chip select stays active. Shifting resumes once `tx_valid` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bit_len | input | LEN_W (5) | Word length minus one |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 1 = sample on trailing edge |
| cfg_cs_sel | input | SEL_W (2) | Selected chip-select line |
| cfg_cs_pol | input | NUM_CS (4) | Per-line active level |
| cfg_cs_sw | input | 1 | Software chip-select mode |
| cfg_cs_val | input | 1 | Raw level for the selected line in software mode |
| cfg_cs_setup | input | SETUP_W (2) | Setup delay in SCLK periods minus one |
| cfg_cs_hold | input | HOLD_W (4) | Hold delay in SCLK periods minus one |
| cfg_cs_keep | input | 1 | Keep chip select active between words |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_blk_words | input | CNT_W (16) | Words per block minus one |
| go | input | 1 | Start a block |
| ready_clr | input | 1 | Clear the ready flag |
| tx_data | input | DATA_W (32) | Transmit word, right-aligned |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_pop | output | 1 | Transmit word taken this cycle |
| rx_data | output | DATA_W (32) | Received word, right-aligned |
| rx_push | output | 1 | Received word valid this cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | NUM_CS (4) | Chip-select lines |
| busy | output | 1 | Block in progress |
| ready | output | 1 | Block-complete flag |

## Verification
The end of a block sets `ready`, and an external `ready_clr` write clears it, so the two can land on the same clock edge. The bench holds `ready_clr` high across the whole completion of a block, which makes the clear coincide with the set edge. It then judges the edge where `busy` falls: `ready` must read 1 there, because the set wins. One cycle later `ready` must read 0, because the clear that is still applied takes effect.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOAD,
        ST_SHIFT,
        ST_HOLD,
        ST_GAP
    } eng_state_e;

endpackage

// File: rtl/spi_half_timer.sv
// Counts SCLK half-periods (two core cycles each) since the last restart.
module spi_half_timer #(
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    output logic              tick,
    output logic [HALF_W-1:0] half_idx
);
    logic sub_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q    <= 1'b0;
            half_idx <= '0;
        end else if (restart) begin
            sub_q    <= 1'b0;
            half_idx <= '0;
        end else begin
            sub_q <= ~sub_q;
            if (sub_q) half_idx <= half_idx + 1'b1;
        end
    end

    assign tick = sub_q;
endmodule

// File: rtl/spi_shift_pair.sv
// Transmit and receive shift registers; transmit word is left-aligned on load.
module spi_shift_pair #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              miso,
    output logic              mosi_bit,
    output logic [DATA_W-1:0] rx_word
);
    localparam logic [LEN_W-1:0] TOP_BIT = LEN_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_word <= '0;
        end else if (load) begin
            tx_q    <= tx_word << (TOP_BIT - len_m1);
            rx_word <= '0;
        end else begin
            if (shift_en)  tx_q    <= {tx_q[DATA_W-2:0], 1'b0};
            if (sample_en) rx_word <= {rx_word[DATA_W-2:0], miso};
        end
    end

    assign mosi_bit = tx_q[DATA_W-1];
endmodule

// File: rtl/spi_cs_drive.sv
// Drives every chip-select line at its inactive level except the selected one.
module spi_cs_drive #(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = $clog2(NUM_CS)
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [NUM_CS-1:0] pol,
    input  logic              sw_mode,
    input  logic              sw_level,
    input  logic              hw_active,
    output logic [NUM_CS-1:0] cs
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        always_comb begin
            if (sel == SEL_W'(i))
                cs[i] = sw_mode ? sw_level : (hw_active ? pol[i] : ~pol[i]);
            else
                cs[i] = ~pol[i];
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int NUM_CS  = 4,
    parameter int SETUP_W = 2,
    parameter int HOLD_W  = 4,
    parameter int LEN_W   = $clog2(DATA_W),
    parameter int SEL_W   = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_bit_len,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [SEL_W-1:0]  cfg_cs_sel,
    input  logic [NUM_CS-1:0] cfg_cs_pol,
    input  logic              cfg_cs_sw,
    input  logic              cfg_cs_val,
    input  logic [SETUP_W-1:0] cfg_cs_setup,
    input  logic [HOLD_W-1:0] cfg_cs_hold,
    input  logic              cfg_cs_keep,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic [CNT_W-1:0]  cfg_blk_words,
    input  logic              go,
    input  logic              ready_clr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_push,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs,
    output logic              busy,
    output logic              ready
);
    localparam int MAX_SH = (HOLD_W > SETUP_W) ? HOLD_W : SETUP_W;
    localparam int HALF_W = ((LEN_W > MAX_SH) ? LEN_W : MAX_SH) + 1;

    eng_state_e        state_q, state_d;
    logic              tick;
    logic [HALF_W-1:0] half_idx;
    logic [CNT_W-1:0]  words_q;
    logic              word_end, setup_end, hold_end, gap_end, last_word;
    logic              load, shift_en, sample_en, cs_active, mosi_bit;

    spi_half_timer #(.HALF_W(HALF_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (state_d != state_q),
        .tick     (tick),
        .half_idx (half_idx)
    );

    spi_shift_pair #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .tx_word   (cfg_tx_en ? tx_data : '0),
        .len_m1    (cfg_bit_len),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .miso      (miso),
        .mosi_bit  (mosi_bit),
        .rx_word   (rx_data)
    );

    spi_cs_drive #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
        .sel       (cfg_cs_sel),
        .pol       (cfg_cs_pol),
        .sw_mode   (cfg_cs_sw),
        .sw_level  (cfg_cs_val),
        .hw_active (cs_active),
        .cs        (cs)
    );

    assign last_word = (words_q == '0);
    assign word_end  = (state_q == ST_SHIFT) && tick && (half_idx == HALF_W'({cfg_bit_len, 1'b1}));
    assign setup_end = (state_q == ST_SETUP) && tick && (half_idx == HALF_W'({cfg_cs_setup, 1'b1}));
    assign hold_end  = (state_q == ST_HOLD)  && tick && (half_idx == HALF_W'({cfg_cs_hold, 1'b1}));
    assign gap_end   = (state_q == ST_GAP)   && tick && (half_idx == HALF_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go) state_d = cfg_cs_sw ? ST_LOAD : ST_SETUP;
            ST_SETUP: if (setup_end) state_d = ST_LOAD;
            ST_LOAD:  if (!cfg_tx_en || tx_valid) state_d = ST_SHIFT;
            ST_SHIFT: if (word_end) begin
                if (last_word)                     state_d = cfg_cs_sw ? ST_IDLE : ST_HOLD;
                else if (cfg_cs_sw || cfg_cs_keep) state_d = ST_LOAD;
                else                               state_d = ST_HOLD;
            end
            ST_HOLD:  if (hold_end) state_d = last_word ? ST_IDLE : ST_GAP;
            ST_GAP:   if (gap_end) state_d = ST_SETUP;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the registered state
    always_comb begin
        busy      = (state_q != ST_IDLE);
        cs_active = (state_q == ST_SETUP) || (state_q == ST_LOAD) ||
                    (state_q == ST_SHIFT) || (state_q == ST_HOLD);
        tx_pop    = (state_q == ST_LOAD) && cfg_tx_en && tx_valid;
        load      = (state_q == ST_LOAD) && (!cfg_tx_en || tx_valid);
        shift_en  = (state_q == ST_SHIFT) && tick && half_idx[0];
        sample_en = (state_q == ST_SHIFT) && tick && !half_idx[0];
        sclk      = (state_q == ST_SHIFT) ? (cfg_cpol ^ (cfg_cpha ? ~half_idx[0] : half_idx[0]))
                                          : cfg_cpol;
        mosi      = (state_q == ST_SHIFT) ? mosi_bit : 1'b0;
    end

    // Word count, receive strobe, completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_q <= '0;
            rx_push <= 1'b0;
            ready   <= 1'b0;
        end else begin
            rx_push <= word_end && cfg_rx_en;
            if (state_q == ST_IDLE && go)
                words_q <= cfg_blk_words;
            else if (!last_word && (hold_end ||
                     (word_end && (cfg_cs_sw || cfg_cs_keep))))
                words_q <= words_q - 1'b1;
            if (state_q != ST_IDLE && state_d == ST_IDLE) ready <= 1'b1;
            else if (ready_clr)                           ready <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_cpol,
    input logic [NUM_CS-1:0] cfg_cs_pol,
    input logic              cfg_tx_en,
    input logic              cfg_rx_en,
    input logic              ready_clr,
    input logic              tx_pop,
    input logic              rx_push,
    input logic              sclk,
    input logic [NUM_CS-1:0] cs,
    input logic              busy,
    input logic              ready
);
    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk == cfg_cpol);                          // R2

    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs ^ ~cfg_cs_pol));                           // R4

    AST_POP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> busy && cfg_tx_en);                         // R9

    AST_PUSH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(cfg_rx_en));                         // R9

    AST_PUSH_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> $past(busy));                              // R10

    AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> !busy && $past(busy));                // R11

    AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ready_clr && !busy |=> !ready);                        // R11
endmodule

bind spi_shift_engine spi_shift_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_cpol   (cfg_cpol),
    .cfg_cs_pol (cfg_cs_pol),
    .cfg_tx_en  (cfg_tx_en),
    .cfg_rx_en  (cfg_rx_en),
    .ready_clr  (ready_clr),
    .tx_pop     (tx_pop),
    .rx_push    (rx_push),
    .sclk       (sclk),
    .cs         (cs),
    .busy       (busy),
    .ready      (ready)
);

// File: tb/test_spi_shift_engine.sv
`timescale 1ns/1ps
module test_spi_shift_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_bit_len = 5'd7;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [1:0]  cfg_cs_sel = 2'd0;
    logic [3:0]  cfg_cs_pol = 4'b0000;
    logic        cfg_cs_sw = 1'b0, cfg_cs_val = 1'b0;
    logic [1:0]  cfg_cs_setup = 2'd0;
    logic [3:0]  cfg_cs_hold = 4'd0;
    logic        cfg_cs_keep = 1'b1, cfg_tx_en = 1'b1, cfg_rx_en = 1'b1;
    logic [15:0] cfg_blk_words = 16'd0;
    logic        go = 1'b0, ready_clr = 1'b0;
    logic [31:0] tx_data = 32'h0;
    logic        tx_valid = 1'b1;
    logic        miso = 1'b0;
    logic        tx_pop, rx_push, sclk, mosi, busy, ready;
    logic [31:0] rx_data;
    logic [3:0]  cs;

    spi_shift_engine i_spi_shift_engine (
        .clk(clk), .rst_n(rst_n), .cfg_bit_len(cfg_bit_len), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_cs_sel(cfg_cs_sel), .cfg_cs_pol(cfg_cs_pol),
        .cfg_cs_sw(cfg_cs_sw), .cfg_cs_val(cfg_cs_val), .cfg_cs_setup(cfg_cs_setup),
        .cfg_cs_hold(cfg_cs_hold), .cfg_cs_keep(cfg_cs_keep), .cfg_tx_en(cfg_tx_en),
        .cfg_rx_en(cfg_rx_en), .cfg_blk_words(cfg_blk_words), .go(go),
        .ready_clr(ready_clr), .tx_data(tx_data), .tx_valid(tx_valid), .tx_pop(tx_pop),
        .rx_data(rx_data), .rx_push(rx_push), .sclk(sclk), .mosi(mosi), .miso(miso),
        .cs(cs), .busy(busy), .ready(ready)
    );

    always #2 clk = ~clk;   // 250 MHz

    int n_chk = 0, n_bad = 0;
    longint cyc = 0;

    // Columns: cpol, cpha, len-1 (6b), transmit word, word the slave returns
    localparam logic [71:0] VEC [0:7] = '{
        {1'b0, 1'b0, 6'd7,  32'h000000A5, 32'h0000003C},
        {1'b0, 1'b1, 6'd15, 32'h0000BEEF, 32'h00001234},
        {1'b1, 1'b0, 6'd31, 32'hDEADBEEF, 32'h0F1E2D3C},
        {1'b1, 1'b1, 6'd0,  32'h00000001, 32'h00000001},
        {1'b0, 1'b0, 6'd4,  32'hFFFFFFF5, 32'h0000000A},
        {1'b1, 1'b1, 6'd23, 32'h0000C0DE, 32'h00ABCDEF},
        {1'b0, 1'b1, 6'd11, 32'h00000800, 32'h00000001},
        {1'b1, 1'b0, 6'd2,  32'h00000006, 32'h00000003}
    };

    // Slave model and bus monitor state
    logic [31:0] slv_tx = 32'h0, slv_rx = 32'h0, slv_cap = 32'h0, rx_cap = 32'h0;
    logic [3:0]  cs_at_edge = 4'h0;
    int bitcnt = 0, n_words = 0, n_edges = 0, n_pops = 0, n_push = 0;
    int n_cs_on = 0, n_gap = 0;
    longint t_cs_on = 0, t_cs_off = 0, t_first = 0, t_last = 0;
    logic prev_sclk = 1'b0, prev_act = 1'b0, cs_act;

    function automatic logic [31:0] msk(input int len);
        return (len >= 31) ? 32'hFFFFFFFF : ((32'h1 << (len + 1)) - 32'h1);
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual=%0d expected=<150000 cycles", cyc);
            finish_run();
        end
    end

    always @(negedge clk) begin
        cs_act = (cs[cfg_cs_sel] == cfg_cs_pol[cfg_cs_sel]);
        if (cs_act && !prev_act) begin n_cs_on++; if (n_cs_on == 1) t_cs_on = cyc; end
        if (!cs_act && prev_act) t_cs_off = cyc;
        if (!cs_act && busy) n_gap++;
        if (sclk != prev_sclk) begin
            n_edges++;
            if (n_edges == 1) begin t_first = cyc; cs_at_edge = cs; end
            t_last = cyc;
            if (sclk == (cfg_cpol ^ !cfg_cpha)) begin
                slv_rx = {slv_rx[30:0], mosi};
                bitcnt++;
                if (bitcnt == int'(cfg_bit_len) + 1) begin
                    slv_cap = slv_rx; slv_rx = 32'h0; n_words++; bitcnt = 0;
                end
                miso = slv_tx[int'(cfg_bit_len) - bitcnt];
            end
        end
        if (tx_pop) n_pops++;
        if (rx_push) begin n_push++; rx_cap = rx_data; end
        prev_sclk = sclk;
        prev_act  = cs_act;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle_and_clear();
        repeat (2) @(negedge clk);
        #0.5;
        bitcnt = 0; n_words = 0; n_edges = 0; n_pops = 0; n_push = 0;
        n_cs_on = 0; n_gap = 0; slv_rx = 32'h0; slv_cap = 32'h0; rx_cap = 32'h0;
        prev_sclk = sclk;
        prev_act  = (cs[cfg_cs_sel] == cfg_cs_pol[cfg_cs_sel]);
        miso = slv_tx[cfg_bit_len];
    endtask

    task automatic defaults();
        cfg_bit_len = 5'd7; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_cs_sel = 2'd0;
        cfg_cs_pol = 4'b0000; cfg_cs_sw = 1'b0; cfg_cs_val = 1'b0; cfg_cs_setup = 2'd0;
        cfg_cs_hold = 4'd0; cfg_cs_keep = 1'b1; cfg_tx_en = 1'b1; cfg_rx_en = 1'b1;
        cfg_blk_words = 16'd0; tx_valid = 1'b1; ready_clr = 1'b0;
    endtask

    task automatic pulse_go();
        go = 1'b1;
        @(negedge clk); #0.5;
        go = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        #0.5;
    endtask

    task automatic clear_ready();
        ready_clr = 1'b1;
        @(negedge clk); #0.5;
        ready_clr = 1'b0;
    endtask

    initial begin
        logic [71:0] v;
        int ln;
        logic [31:0] m;
        repeat (3) @(negedge clk);
        // Reset state
        chk(busy == 1'b0, "R10 busy after reset", busy, 0);
        chk(ready == 1'b0, "R11 ready after reset", ready, 0);
        chk(sclk == 1'b0, "R2 sclk idle after reset", sclk, 0);
        chk(cs == 4'hF, "R4 all lines inactive after reset", cs, 4'hF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_pop == 1'b0 && rx_push == 1'b0, "R9 no traffic after reset", {tx_pop, rx_push}, 0);

        // Vector table: one word per block, all four modes, several lengths
        for (int i = 0; i < 8; i++) begin
            v = VEC[i];
            defaults();
            cfg_cpol = v[71]; cfg_cpha = v[70]; cfg_bit_len = v[68:64];
            ln = int'(v[69:64]); m = msk(ln);
            tx_data = v[63:32]; slv_tx = v[31:0];
            settle_and_clear();
            chk(sclk == cfg_cpol, "R2 idle level", sclk, cfg_cpol);
            pulse_go();
            wait_done();
            chk(slv_cap == (v[63:32] & m), "R1 word on MOSI", slv_cap, v[63:32] & m);
            chk(rx_cap == (v[31:0] & m), "R3 received word", rx_cap, v[31:0] & m);
            chk(n_push == 1 && n_pops == 1, "R10 one word per block", {n_pops, n_push}, 64'h100000001);
            chk(n_edges == 2 * (ln + 1), "R2 edge count", n_edges, 2 * (ln + 1));
            chk(t_last - t_first == 2 * (2 * ln + 1), "R2 edge spacing", t_last - t_first, 2 * (2 * ln + 1));
            chk(ready == 1'b1, "R11 ready on completion", ready, 1);
            clear_ready();
            chk(ready == 1'b0, "R11 ready cleared", ready, 0);
        end

        // R6: setup delay, CPHA=1, setup field 2
        defaults(); cfg_cpha = 1'b1; cfg_cs_setup = 2'd2; tx_data = 32'h5A; slv_tx = 32'h0;
        settle_and_clear(); pulse_go(); wait_done();
        chk(t_first - t_cs_on == 13, "R6 setup cycles", t_first - t_cs_on, 13);
        clear_ready();

        // R7: hold delay, CPHA=0, hold field 5
        defaults(); cfg_cs_hold = 4'd5; tx_data = 32'hC3;
        settle_and_clear(); pulse_go(); wait_done();
        chk(t_cs_off - t_last == 24, "R7 hold cycles", t_cs_off - t_last, 24);
        clear_ready();

        // R8: three words with chip select kept, then released between words
        defaults(); cfg_blk_words = 16'd2; tx_data = 32'h96; slv_tx = 32'h69;
        settle_and_clear(); pulse_go(); wait_done();
        chk(n_cs_on == 1 && n_gap == 0, "R8 kept across words", n_cs_on, 1);
        chk(n_push == 3 && n_words == 3, "R10 three-word block", n_push, 3);
        clear_ready();
        cfg_cs_keep = 1'b0;
        settle_and_clear(); pulse_go(); wait_done();
        chk(n_cs_on == 3, "R8 assertions when released", n_cs_on, 3);
        chk(n_gap == 8, "R8 release cycles between words", n_gap, 8);
        chk(slv_cap == 32'h96 && rx_cap == 32'h69, "R8 data with release", slv_cap, 32'h96);
        clear_ready();

        // R9: transmit disabled, then receive disabled
        defaults(); cfg_tx_en = 1'b0; tx_data = 32'hFF; slv_tx = 32'hA7;
        settle_and_clear(); pulse_go(); wait_done();
        chk(n_pops == 0, "R9 no pop with tx off", n_pops, 0);
        chk(slv_cap == 32'h0 && n_words == 1, "R9 MOSI low while clocking", slv_cap, 0);
        chk(rx_cap == 32'hA7, "R9 receive with tx off", rx_cap, 32'hA7);
        clear_ready();
        cfg_tx_en = 1'b1; cfg_rx_en = 1'b0; tx_data = 32'h3E;
        settle_and_clear(); pulse_go(); wait_done();
        chk(n_push == 0, "R9 no push with rx off", n_push, 0);
        chk(slv_cap == 32'h3E, "R9 transmit with rx off", slv_cap, 32'h3E);
        clear_ready();

        // R4: line 2 selected, mixed polarities
        defaults(); cfg_cs_sel = 2'd2; cfg_cs_pol = 4'b0101; tx_data = 32'h11;
        settle_and_clear();
        chk(cs == 4'b1010, "R4 idle levels", cs, 4'b1010);
        pulse_go(); wait_done();
        chk(cs_at_edge == 4'b1110, "R4 levels during shift", cs_at_edge, 4'b1110);
        chk(slv_cap == 32'h11, "R4 data on selected line", slv_cap, 32'h11);
        clear_ready();

        // R5: software chip select
        defaults(); cfg_cs_sel = 2'd2; cfg_cs_sw = 1'b1; cfg_cs_val = 1'b1; tx_data = 32'h4D;
        settle_and_clear();
        chk(cs[2] == 1'b1, "R5 raw level high when idle", cs[2], 1);
        cfg_cs_val = 1'b0;
        settle_and_clear();
        pulse_go(); wait_done();
        chk(n_cs_on == 0 && cs[2] == 1'b0, "R5 level held through block", {n_cs_on, cs[2]}, 0);
        chk(slv_cap == 32'h4D, "R5 data in software mode", slv_cap, 32'h4D);
        clear_ready();

        // R12: transmit stall
        defaults(); tx_valid = 1'b0; tx_data = 32'hB2;
        settle_and_clear(); pulse_go();
        repeat (40) @(negedge clk);
        #0.5;
        chk(n_edges == 0 && sclk == 1'b0, "R12 SCLK parked", n_edges, 0);
        chk(busy == 1'b1 && cs[0] == 1'b0, "R12 CS held in stall", {busy, cs[0]}, 2);
        tx_valid = 1'b1;
        wait_done();
        chk(slv_cap == 32'hB2, "R12 word after resume", slv_cap, 32'hB2);
        clear_ready();

        // R10: go while busy has no effect
        defaults(); cfg_blk_words = 16'd1; tx_data = 32'h77;
        settle_and_clear(); pulse_go();
        repeat (10) @(negedge clk);
        #0.5;
        pulse_go();
        wait_done();
        repeat (20) @(negedge clk);
        chk(busy == 1'b0 && n_push == 2, "R10 second go ignored", n_push, 2);
        chk(n_cs_on == 1, "R10 single block", n_cs_on, 1);
        clear_ready();

        // R11: clear and completion on the same edge; set wins
        defaults(); tx_data = 32'h21;
        settle_and_clear();
        ready_clr = 1'b1;
        pulse_go();
        @(negedge clk);
        while (busy) @(negedge clk);
        chk(ready == 1'b1, "R11 set wins over clear", ready, 1);
        @(negedge clk);
        chk(ready == 1'b0, "R11 clear after set", ready, 0);
        ready_clr = 1'b0;

        finish_run();
    end
endmodule